// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block sits between the processor's store path and main memory, behind a write-through cache or in front of a memory region that is not cached. It collects processor stores into one 32-byte line image with a valid flag for every byte. Repeated stores to the same bytes merge in place, so memory sees one burst per line instead of one transaction per store.

The buffer holds the stored bytes until a trigger fires. The triggers are: every byte valid, a store to a different 32-byte line, or an explicit flush request. When a trigger fires, the buffer presents the line address, the full line of data and the byte mask on a valid/ready burst port. It holds them there until memory accepts. While this drain is in progress the store side is stalled. Once memory takes the burst, the buffer is empty and ready for the next line.

Top module: `wc_write_buffer`

## Requirements
- R1: After reset the buffer is empty: `st_ready` is 1, `burst_valid` is 0 and `pending` is 0.
- R2: A store is taken on a rising edge where `st_valid` and `st_ready` are both high. Its word lane is `st_addr[4:2]`. `st_be[k]` marks byte k of `st_data` (bits 8k+7:8k) as valid at line byte 4*lane+k. A partially filled buffer with no trigger sends nothing to memory, and `pending` stays 1.
- R3: A later store to a byte that is already valid replaces that byte's data. The byte mask becomes the union of all enables taken for the line.
- R4: When a store makes all 32 byte-valid bits set, `burst_valid` rises in the following cycle without any flush request.
- R5: A store whose address bits [31:5] differ from the held line, arriving at a non-empty buffer, first drains the old line with `st_ready` held low. The store is then taken into the empty buffer and appears alone in the next burst.
- R6: `flush` high on a non-empty buffer starts a burst in the next cycle. `flush` on an empty buffer has no effect: `burst_valid` stays 0.
- R7: During a burst, `burst_addr` is the held line address with bits [4:0] zero. Line byte i is on `burst_data[8i+7:8i]` and its valid flag is on `burst_mask[i]`. Bytes with a clear mask bit read as zero. All three outputs stay stable while `burst_ready` is low.
- R8: In the cycle after `burst_valid` and `burst_ready` are both high, the buffer is empty: `pending` is 0, `st_ready` is 1, and no old byte reappears in the mask or data of the next line.
- R9: `st_ready` is low for the whole drain. When `flush` and a same-line store arrive together at a non-empty buffer, the flush wins. The store waits and lands in the next line image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Processor store request |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W | Byte address of the store word |
| st_data | input | 8*WORD_BYTES | Store data, byte k in bits 8k+7:8k |
| st_be | input | WORD_BYTES | Byte enables of the store |
| flush | input | 1 | Request to drain a non-empty buffer |
| burst_valid | output | 1 | Line burst offered to memory |
| burst_ready | input | 1 | Memory accepts the burst |
| burst_addr | output | ADDR_W | Line-aligned burst address |
| burst_data | output | 8*LINE_BYTES | Line image |
| burst_mask | output | LINE_BYTES | Per-byte valid mask of the burst |
| pending | output | 1 | Buffer holds at least one valid byte |

## Verification
The hardest situation to reach is a store that arrives in the same cycle as a trigger. The store must then stall through the whole drain while its own request stays asserted, and land afterwards in a clean line. The stimulus reaches it by holding a line-crossing store, and separately a same-line store paired with a flush, on the inputs across the drain. It also keeps memory stalled for extra cycles. The bench then checks the stalled ready, the stable burst of the old line, and a following burst holding only the late store's bytes.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
   typedef enum logic [0:0] {
      WCB_FILL  = 1'b0,
      WCB_DRAIN = 1'b1
   } wcb_state_e;
endpackage

// File: rtl/wcb_byte_cell.sv
module wcb_byte_cell (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic       clr,
   input  logic [7:0] din,
   output logic [7:0] q,
   output logic       vld
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         q   <= 8'h00;
         vld <= 1'b0;
      end else if (we) begin
         q   <= din;
         vld <= 1'b1;
      end
   end
endmodule

// File: rtl/wcb_line_store.sv
module wcb_line_store #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int WORD_BYTES = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             acc,
   input  logic                             clr,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [8*WORD_BYTES-1:0]          data,
   input  logic [WORD_BYTES-1:0]            be,
   output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] tag_q,
   output logic [8*LINE_BYTES-1:0]          line_q,
   output logic [LINE_BYTES-1:0]            mask_q,
   output logic                             empty,
   output logic                             hit,
   output logic                             fills
);
   localparam int OFS_W  = $clog2(LINE_BYTES);
   localparam int WB_W   = $clog2(WORD_BYTES);
   localparam int TAG_W  = ADDR_W - OFS_W;
   localparam int LANES  = LINE_BYTES / WORD_BYTES;
   localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

   logic [LANE_W-1:0]     lane_sel;
   logic [LINE_BYTES-1:0] hit_bits;

   generate
      if (LANES == 1) begin : g_one_lane
         assign lane_sel = '0;
      end else begin : g_many_lanes
         assign lane_sel = addr[OFS_W-1:WB_W];
      end
   endgenerate

   for (genvar i = 0; i < LINE_BYTES; i++) begin : g_byte
      localparam int LANE = i / WORD_BYTES;
      localparam int K    = i % WORD_BYTES;
      assign hit_bits[i] = (lane_sel == LANE_W'(LANE)) && be[K];
      wcb_byte_cell u_cell (
         .clk (clk),
         .rst_n (rst_n),
         .we  (acc && hit_bits[i]),
         .clr (clr),
         .din (data[8*K +: 8]),
         .q   (line_q[8*i +: 8]),
         .vld (mask_q[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) tag_q <= '0;
      else if (acc) tag_q <= addr[ADDR_W-1:OFS_W];
   end

   assign empty = (mask_q == '0);
   assign hit   = (addr[ADDR_W-1:OFS_W] == tag_q);
   assign fills = &(mask_q | hit_bits);

   // R5: a store joins a non-empty image only when it belongs to the same line
   assert_acc_same_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !empty) |-> hit);
   // R8: a clear leaves no valid byte behind
   assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (mask_q == '0) && (line_q == '0));
   // R3: taken enables always end up valid
   assert_enable_sets_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !clr) |=> ((mask_q & $past(hit_bits)) == $past(hit_bits)));

   wire [TAG_W-1:0] unused_tag_w = '0;
   wire unused_ok = &{1'b0, unused_tag_w};
endmodule

// File: rtl/wcb_ctrl.sv
module wcb_ctrl
   import wcb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic st_valid,
   input  logic flush,
   input  logic burst_ready,
   input  logic empty,
   input  logic hit,
   input  logic fills,
   output logic st_ready,
   output logic acc,
   output logic clr,
   output logic burst_valid
);
   wcb_state_e state_q, state_d;
   logic       drain_start;

   assign drain_start = (state_q == WCB_FILL) && !empty &&
                        (flush || (st_valid && !hit));
   assign st_ready    = (state_q == WCB_FILL) && !drain_start;
   assign acc         = st_valid && st_ready;
   assign burst_valid = (state_q == WCB_DRAIN);
   assign clr         = burst_valid && burst_ready;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         WCB_FILL:  if (drain_start || (acc && fills)) state_d = WCB_DRAIN;
         WCB_DRAIN: if (burst_ready) state_d = WCB_FILL;
         default:   state_d = WCB_FILL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= WCB_FILL;
      else        state_q <= state_d;
   end

   // R6: a flush on a non-empty idle buffer starts the drain next cycle
   assert_flush_drains_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == WCB_FILL && flush && !empty) |=> burst_valid);
   // R8: a taken burst returns control to the fill state
   assert_drain_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !burst_valid);
endmodule

// File: rtl/wc_write_buffer.sv
module wc_write_buffer #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int WORD_BYTES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    st_valid,
   output logic                    st_ready,
   input  logic [ADDR_W-1:0]       st_addr,
   input  logic [8*WORD_BYTES-1:0] st_data,
   input  logic [WORD_BYTES-1:0]   st_be,
   input  logic                    flush,
   output logic                    burst_valid,
   input  logic                    burst_ready,
   output logic [ADDR_W-1:0]       burst_addr,
   output logic [8*LINE_BYTES-1:0] burst_data,
   output logic [LINE_BYTES-1:0]   burst_mask,
   output logic                    pending
);
   localparam int OFS_W = $clog2(LINE_BYTES);
   localparam int TAG_W = ADDR_W - OFS_W;

   if ((1 << OFS_W) != LINE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if ((1 << $clog2(WORD_BYTES)) != WORD_BYTES || WORD_BYTES > LINE_BYTES) begin : g_bad_word
      $error("WORD_BYTES must be a power of two no larger than LINE_BYTES");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("ADDR_W must exceed the line offset width");
   end

   logic             acc, clr, empty, hit, fills;
   logic [TAG_W-1:0] tag_q;

   wcb_line_store #(
      .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .acc(acc), .clr(clr),
      .addr(st_addr), .data(st_data), .be(st_be),
      .tag_q(tag_q), .line_q(burst_data), .mask_q(burst_mask),
      .empty(empty), .hit(hit), .fills(fills)
   );

   wcb_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .flush(flush),
      .burst_ready(burst_ready), .empty(empty), .hit(hit), .fills(fills),
      .st_ready(st_ready), .acc(acc), .clr(clr), .burst_valid(burst_valid)
   );

   assign burst_addr = {tag_q, {OFS_W{1'b0}}};
   assign pending    = !empty;

   // R7: the offered burst holds still until memory accepts it
   assert_burst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_valid && !burst_ready) |=> burst_valid && $stable(burst_addr) &&
      $stable(burst_mask) && $stable(burst_data));
   // R8: the buffer is empty right after the burst handshake
   assert_empty_after_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_valid && burst_ready) |=> !pending && st_ready);
   // R4: a complete line is never left waiting in the fill state
   assert_full_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (&burst_mask) |-> burst_valid);
   // R6: a burst always carries at least one valid byte
   assert_burst_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      burst_valid |-> (|burst_mask));
   // R9: no store is taken while a drain is in progress
   assert_no_store_in_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
      burst_valid |-> !st_ready);
endmodule

// File: tb/tb_wc_write_buffer.sv
module tb_wc_write_buffer;
   localparam int AW = 32;
   localparam int LB = 32;
   localparam int WB = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           st_valid = 1'b0;
   logic           st_ready;
   logic [AW-1:0]  st_addr = '0;
   logic [8*WB-1:0] st_data = '0;
   logic [WB-1:0]  st_be = '0;
   logic           flush = 1'b0;
   logic           burst_valid;
   logic           burst_ready = 1'b0;
   logic [AW-1:0]  burst_addr;
   logic [8*LB-1:0] burst_data;
   logic [LB-1:0]  burst_mask;
   logic           pending;

   always #10 clk = ~clk;

   wc_write_buffer #(.ADDR_W(AW), .LINE_BYTES(LB), .WORD_BYTES(WB)) dut (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
      .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .flush(flush),
      .burst_valid(burst_valid), .burst_ready(burst_ready),
      .burst_addr(burst_addr), .burst_data(burst_data),
      .burst_mask(burst_mask), .pending(pending)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [8*LB-1:0] m_data = '0;
   logic [LB-1:0]   m_mask = '0;
   logic [AW-6:0]   m_tag = '0;

   task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
      int lane;
      lane = int'(a[4:2]);
      m_tag = a[AW-1:5];
      for (int k = 0; k < WB; k++) begin
         if (be[k]) begin
            m_data[(lane*WB+k)*8 +: 8] = d[k*8 +: 8];
            m_mask[lane*WB+k] = 1'b1;
         end
      end
   endtask

   task automatic put(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
      st_addr = a; st_data = d; st_be = be; st_valid = 1'b1;
      @(negedge clk);
      st_valid = 1'b0;
      model_write(a, d, be);
   endtask

   task automatic do_flush();
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic take();
      burst_ready = 1'b1;
      @(negedge clk);
      burst_ready = 1'b0;
      m_data = '0;
      m_mask = '0;
   endtask

   task automatic chk_burst(input string tag);
      check({tag, " burst_valid"}, burst_valid, 1'b1);
      check({tag, " burst_addr"}, burst_addr, {m_tag, 5'b0});
      check({tag, " burst_mask"}, burst_mask, m_mask);
      check({tag, " burst_data"}, burst_data, m_data);
   endtask

   task automatic t_reset();
      check("R1 st_ready", st_ready, 1'b1);
      check("R1 burst_valid", burst_valid, 1'b0);
      check("R1 pending", pending, 1'b0);
   endtask

   task automatic t_partial_flush();
      put(32'h0000_0100, 32'hAABB_CCDD, 4'hF);
      put(32'h0000_010C, 32'h1234_5678, 4'h3);
      repeat (3) @(negedge clk);
      check("R2 no burst while partial", burst_valid, 1'b0);
      check("R2 pending", pending, 1'b1);
      do_flush();
      chk_burst("R6/R7 flush");
      repeat (3) @(negedge clk);
      chk_burst("R7 held while stalled");
      check("R9 st_ready in drain", st_ready, 1'b0);
      take();
      check("R8 pending after accept", pending, 1'b0);
      check("R8 st_ready after accept", st_ready, 1'b1);
      check("R8 burst_valid after accept", burst_valid, 1'b0);
   endtask

   task automatic t_merge();
      put(32'h0000_0200, 32'h1122_3344, 4'hF);
      put(32'h0000_0200, 32'h5566_7788, 4'h5);
      put(32'h0000_0204, 32'h9900_0000, 4'h8);
      check("R3 merged no burst", burst_valid, 1'b0);
      do_flush();
      chk_burst("R3 merge");
      check("R3 byte0 newest", burst_data[7:0], 8'h88);
      check("R3 byte1 kept", burst_data[15:8], 8'h33);
      take();
   endtask

   task automatic t_flush_empty();
      do_flush();
      repeat (2) @(negedge clk);
      check("R6 flush on empty", burst_valid, 1'b0);
      check("R6 pending on empty", pending, 1'b0);
   endtask

   task automatic t_full();
      for (int i = 0; i < 7; i++) put(32'h0000_0300 + 32'(4*i), 32'hA0B0_C0D0 + 32'(i), 4'hF);
      check("R4 not yet full", burst_valid, 1'b0);
      put(32'h0000_031C, 32'hDEAD_BEEF, 4'hF);
      chk_burst("R4 full triggers");
      check("R4 full mask", burst_mask, 32'hFFFF_FFFF);
      check("R9 st_ready in full drain", st_ready, 1'b0);
      take();
      check("R8 empty after full", pending, 1'b0);
   endtask

   task automatic t_mismatch();
      put(32'h0000_0408, 32'hCAFE_F00D, 4'hF);
      st_addr = 32'h0000_0420; st_data = 32'h0102_0304; st_be = 4'hF; st_valid = 1'b1;
      #1;
      check("R5 st_ready low on other line", st_ready, 1'b0);
      @(negedge clk);
      chk_burst("R5 old line drained");
      check("R9 st_ready in drain", st_ready, 1'b0);
      @(negedge clk);
      chk_burst("R7 old line held");
      take();
      #1;
      check("R8 st_ready after drain", st_ready, 1'b1);
      @(negedge clk);
      st_valid = 1'b0;
      model_write(32'h0000_0420, 32'h0102_0304, 4'hF);
      check("R5 new store pending", pending, 1'b1);
      check("R5 no burst yet", burst_valid, 1'b0);
      do_flush();
      chk_burst("R5/R8 new line alone");
      take();
   endtask

   task automatic t_flush_vs_store();
      put(32'h0000_0500, 32'h1111_1111, 4'hF);
      flush = 1'b1;
      st_addr = 32'h0000_0504; st_data = 32'h2222_2222; st_be = 4'hF; st_valid = 1'b1;
      #1;
      check("R9 flush beats store", st_ready, 1'b0);
      @(negedge clk);
      flush = 1'b0;
      chk_burst("R9 burst excludes waiting store");
      take();
      #1;
      check("R9 store taken after drain", st_ready, 1'b1);
      @(negedge clk);
      st_valid = 1'b0;
      model_write(32'h0000_0504, 32'h2222_2222, 4'hF);
      do_flush();
      chk_burst("R9 waiting store in next line");
      take();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_partial_flush();
      t_merge();
      t_flush_empty();
      t_full();
      t_mismatch();
      t_flush_vs_store();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule